// File: doc/BRIEF.md
# Protected Self-Timed Programming Sequencer

This block sits behind the serial command decoder of a small word-organised non-volatile memory. It receives each decoded command as a one-cycle `cmd_valid` strobe carrying an operation code, a word address and a data word. It keeps the erase/write enable latch and accepts a programming command only while that latch is set. The programming cycle does not start when the command arrives. It starts on the clock after chip select falls, and from then on it runs from the system clock alone, without any serial clock edges.

A programming cycle drives a simple write port into the word array. A single-word erase writes all ones to one word. A single-word write first erases its word, then stores the data half-way through the cycle. Erase-all sweeps every word to all ones. Write-all first sweeps every word to all ones, then sweeps every word to the data.

Cycle lengths are parameters counted in clock ticks. Their default ratio is 2:3:6 for word operations, erase-all and write-all. When chip select is raised while a cycle is running, `do_en` drives a ready/busy indication. A power-good input gates all programming.

Top module: `prog_seq`

## Requirements
- R1: After reset the enable latch is clear. Op code 1 (enable) sets it and op code 2 (disable) clears it. Deasserting `pwr_good` clears it on the next clock.
- R2: While the latch is clear, programming commands are ignored: no cycle starts and the array sees no write. The programming op codes are 3 (erase word), 4 (write word), 5 (erase all) and 6 (write all). Op code 0 (read) and unknown codes never start a cycle.
- R3: Erase word writes 16'hFFFF to the addressed word, once, on the first tick of the cycle.
- R4: Write word writes all ones to its word on tick 0 and then the data on tick T_WORD/2. Both writes go to the same address.
- R5: Erase all writes all ones to words 0..DEPTH-1, in ascending order, on ticks 0..DEPTH-1.
- R6: Write all first performs the erase-all sweep. It then writes the data to words 0..DEPTH-1, in ascending order, starting at tick T_WRAL/2.
- R7: An accepted command starts a cycle on the first clock at which `cs` is sampled low after being high. `busy` is then high for exactly T_WORD, T_ERAL or T_WRAL clocks, depending on the operation. A `cs` fall with no accepted command starts nothing.
- R8: Once a cycle has started, `do_en` equals `cs`, and `do_val` is 0 while busy and 1 when ready. The indication lasts until `cs` is low with the cycle finished. If `cs` stays low for the whole cycle, no indication follows.
- R9: Lowering `cs` during a cycle does not shorten or abort it.
- R10: Commands that arrive while `busy` is high are ignored. This includes enable and disable.
- R11: While `pwr_good` is low the array sees no write. A running cycle ends at once, and a pending command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply-good indication, high when programming is safe |
| cs | input | 1 | Chip select, sampled each clock |
| cmd_valid | input | 1 | One-cycle strobe for a fully received command |
| cmd_op | input | 3 | Operation code (0 read, 1 enable, 2 disable, 3 erase word, 4 write word, 5 erase all, 6 write all) |
| cmd_addr | input | AW | Word address of the command |
| cmd_data | input | DW | Data word of the command |
| busy | output | 1 | High while a programming cycle runs |
| arr_we | output | 1 | Array word write enable |
| arr_addr | output | AW | Array word address |
| arr_wdata | output | DW | Array write data |
| do_en | output | 1 | Status output drive enable |
| do_val | output | 1 | Status value, 1 ready and 0 busy |

## Verification
The checker watches every cycle for the following:
- an array write happening outside a cycle or without supply-good;
- a cycle starting without the enable latch set, or without a chip-select fall;
- status being driven while chip select is low, or with the wrong polarity;
- the latch changing during a cycle or surviving a supply drop.

Some behaviour only the directed scenarios can show. These include the exact address and data order of the erase and write sweeps and the precise cycle lengths per operation. They also include the status indication staying silent when chip select stays low, a cycle surviving chip select going low, and a supply drop cutting off the data phase of a word write.

// File: rtl/prog_seq_pkg.sv
// Shared operation codes and helpers for the programming sequencer.
// Assumes the command decoder presents codes in exactly this encoding.
package prog_seq_pkg;
    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_EWEN  = 3'd1,
        OP_EWDS  = 3'd2,
        OP_ERASE = 3'd3,
        OP_WRITE = 3'd4,
        OP_ERAL  = 3'd5,
        OP_WRAL  = 3'd6
    } op_e;

    // True for the four codes that start a self-timed cycle.
    function automatic logic is_prog(input logic [2:0] op);
        return (op == OP_ERASE) || (op == OP_WRITE) ||
               (op == OP_ERAL)  || (op == OP_WRAL);
    endfunction
endpackage

// File: rtl/prog_seq_enable.sv
// Erase/write enable latch.
// Cleared by reset and by loss of supply-good; set and cleared by enable/disable.
// Assumes cmd_valid is a single-cycle strobe; commands while busy are dropped.
module prog_seq_enable
    import prog_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       busy,
    output logic       wel
);
    // Latch update: supply loss wins, then enable/disable when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            wel <= 1'b0;
        end else if (cmd_valid && !busy) begin
            if (cmd_op == OP_EWEN)      wel <= 1'b1;
            else if (cmd_op == OP_EWDS) wel <= 1'b0;
        end
    end
endmodule

// File: rtl/prog_seq_engine.sv
// Self-timed cycle engine.
// Counts ticks from a start pulse and issues array writes for each phase:
// an erase phase at tick 0 (or a sweep for whole-array ops) and a program
// phase at half the cycle length (or a sweep for write-all).
// Assumes T_WORD >= 4, T_ERAL >= DEPTH, T_WRAL/2 >= DEPTH and AW <= counter width.
module prog_seq_engine
    import prog_seq_pkg::*;
#(
    parameter int AW     = 4,
    parameter int DW     = 16,
    parameter int T_WORD = 40,
    parameter int T_ERAL = 60,
    parameter int T_WRAL = 120
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          busy,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata
);
    localparam int DEPTH = 1 << AW;
    localparam int TA    = (T_ERAL > T_WORD) ? T_ERAL : T_WORD;
    localparam int TMAX  = (T_WRAL > TA) ? T_WRAL : TA;
    localparam int CW    = $clog2(TMAX + 1);

    logic [CW-1:0] tick, total, half;
    logic [2:0]    op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          is_all, erase_hit, prog_hit;

    // Cycle length for the latched operation.
    always_comb begin
        case (op_q)
            OP_ERASE, OP_WRITE: total = CW'(T_WORD);
            OP_ERAL:            total = CW'(T_ERAL);
            default:            total = CW'(T_WRAL);
        endcase
        half = total >> 1;
    end

    // Phase decode: which write, if any, this tick issues.
    always_comb begin
        is_all    = (op_q == OP_ERAL) || (op_q == OP_WRAL);
        erase_hit = is_all ? (tick < CW'(DEPTH)) : (tick == '0);
        if (op_q == OP_WRITE)
            prog_hit = (tick == half);
        else if (op_q == OP_WRAL)
            prog_hit = (tick >= half) && (tick < half + CW'(DEPTH));
        else
            prog_hit = 1'b0;
        arr_we    = busy && pwr_good && (erase_hit || prog_hit);
        arr_wdata = prog_hit ? data_q : '1;
        if (!is_all)       arr_addr = addr_q;
        else if (prog_hit) arr_addr = AW'(tick - half);
        else               arr_addr = AW'(tick);
    end

    // Cycle state: latch the command on start, count ticks, stop at the end or on supply loss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            tick   <= '0;
            op_q   <= OP_READ;
            addr_q <= '0;
            data_q <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            tick   <= '0;
            op_q   <= op;
            addr_q <= addr;
            data_q <= data;
        end else if (busy) begin
            if (!pwr_good || tick == total - 1'b1) busy <= 1'b0;
            tick <= tick + 1'b1;
        end
    end
endmodule

// File: rtl/prog_seq_status.sv
// Ready/busy indication.
// Armed when a cycle starts. It drives while cs is high and disarms once cs
// is low with the cycle finished, so a cycle spent entirely under a low cs
// leaves nothing to report.
module prog_seq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic start,
    input  logic busy,
    output logic do_en,
    output logic do_val
);
    logic armed;

    // Arm on start, disarm when idle and deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)            armed <= 1'b0;
        else if (start)        armed <= 1'b1;
        else if (!busy && !cs) armed <= 1'b0;
    end

    // Drive only while selected; the value is the inverted busy flag.
    always_comb begin
        do_en  = cs && armed;
        do_val = !busy;
    end
endmodule

// File: rtl/prog_seq.sv
// Write-protected self-timed programming sequencer (top).
// Holds an accepted programming command until chip select falls, then hands
// it to the cycle engine. Inputs are assumed already synchronous to clk.
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter int AW     = 4,
    parameter int DW     = 16,
    parameter int T_WORD = 40,
    parameter int T_ERAL = 60,
    parameter int T_WRAL = 120
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          cs,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    output logic          busy,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic          do_en,
    output logic          do_val
);
    logic          wel, cs_q, cs_fall, start;
    logic          pend_v;
    logic [2:0]    pend_op;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;

    // Chip-select history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs;
    end

    // Edge detect and start qualification.
    always_comb begin
        cs_fall = cs_q && !cs;
        start   = cs_fall && pend_v && pwr_good && !busy;
    end

    // Pending command: captured when allowed, consumed or dropped on cs fall or supply loss.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good || cs_fall) begin
            pend_v <= 1'b0;
        end else if (cmd_valid && !busy && wel && is_prog(cmd_op)) begin
            pend_v    <= 1'b1;
            pend_op   <= cmd_op;
            pend_addr <= cmd_addr;
            pend_data <= cmd_data;
        end
    end

    prog_seq_enable u_enable (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .busy(busy), .wel(wel)
    );

    prog_seq_engine #(
        .AW(AW), .DW(DW), .T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .start(start),
        .op(pend_op), .addr(pend_addr), .data(pend_data),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    prog_seq_status u_status (
        .clk(clk), .rst_n(rst_n), .cs(cs), .start(start), .busy(busy),
        .do_en(do_en), .do_val(do_val)
    );
endmodule

// File: rtl/prog_seq_checker.sv
// Protocol checker for prog_seq, attached with bind; observes ports and the enable latch.
module prog_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic cs,
    input logic busy,
    input logic wel,
    input logic arr_we,
    input logic do_en,
    input logic do_val
);
    p_we_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
    p_we_needs_power_r11: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> pwr_good);
    p_status_polarity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        do_en |-> (do_val == !busy));
    p_status_needs_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        do_en |-> cs);
    p_power_clears_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !wel);
    p_start_on_cs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!cs));
    p_start_needs_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));
    p_latch_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pwr_good) |=> $stable(wel));
endmodule

bind prog_seq prog_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs(cs), .busy(busy),
    .wel(wel), .arr_we(arr_we), .do_en(do_en), .do_val(do_val)
);

// File: tb/prog_seq_test.sv
`timescale 1ns/1ps
module prog_seq_test;
    localparam int AW = 4, DW = 16, DEPTH = 16;
    localparam int T_WORD = 40, T_ERAL = 60, T_WRAL = 120;

    logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b1, cs = 1'b0, cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic busy, arr_we, do_en, do_val;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_wdata;

    int checks = 0, errors = 0;
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] log_a [64];
    logic [DW-1:0] log_d [64];
    int nlog = 0, busy_cnt = 0;

    always #2.5 clk = ~clk;

    prog_seq #(.AW(AW), .DW(DW), .T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs(cs), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .do_en(do_en), .do_val(do_val)
    );

    // Array model and write log, sampled between edges.
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            mem[arr_addr] = arr_wdata;
            if (nlog < 64) begin log_a[nlog] = arr_addr; log_d[nlog] = arr_wdata; end
            nlog++;
        end
        if (rst_n && busy) busy_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        nlog = 0; busy_cnt = 0;
    endtask

    // Issue one command while selected, then deselect.
    task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk) cs = 1'b1;
        @(negedge clk) begin cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; end
        @(negedge clk) cmd_valid = 1'b0;
        @(negedge clk) cs = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check(busy == 0 && arr_we == 0 && do_en == 0, "R1 reset outputs", {busy, arr_we, do_en}, 0);
    endtask

    task automatic t_locked();
        clear_logs();
        send(3'd4, 4'd2, 16'h1111);
        idle(T_WORD + 4);
        check(nlog == 0 && busy_cnt == 0, "R2 write ignored while locked", nlog + busy_cnt, 0);
        clear_logs();
        send(3'd1, 4'd0, 16'h0);
        send(3'd0, 4'd2, 16'h0);
        idle(8);
        check(busy_cnt == 0, "R2 read starts no cycle", busy_cnt, 0);
    endtask

    task automatic t_write_word();
        clear_logs();
        send(3'd4, 4'd3, 16'hA5A5);
        idle(T_WORD + 4);
        check(nlog == 2 && log_a[0] == 4'd3 && log_d[0] == 16'hFFFF, "R4 erase before write", log_d[0], 16'hFFFF);
        check(log_a[1] == 4'd3 && log_d[1] == 16'hA5A5, "R4 data written", log_d[1], 16'hA5A5);
        check(mem[3] == 16'hA5A5, "R4 stored word", mem[3], 16'hA5A5);
        check(busy_cnt == T_WORD, "R7 word cycle length", busy_cnt, T_WORD);
    endtask

    task automatic t_status_polled();
        clear_logs();
        send(3'd4, 4'd7, 16'h5A5A);
        idle(3);
        cs = 1'b1;
        idle(1);
        check(do_en == 1 && do_val == 0, "R8 busy shown", {do_en, do_val}, 2);
        idle(T_WORD);
        check(do_en == 1 && do_val == 1, "R8 ready shown", {do_en, do_val}, 3);
        cs = 1'b0;
        idle(2);
        cs = 1'b1;
        idle(1);
        check(do_en == 0, "R8 status cleared after deselect", do_en, 0);
        cs = 1'b0;
        idle(2);
    endtask

    task automatic t_status_silent();
        clear_logs();
        send(3'd3, 4'd7, 16'h0);
        idle(T_WORD + 4);
        cs = 1'b1;
        idle(1);
        check(do_en == 0, "R8 no status when cs low all cycle", do_en, 0);
        check(mem[7] == 16'hFFFF && nlog == 1, "R3 word erased", mem[7], 16'hFFFF);
        cs = 1'b0;
        idle(2);
    endtask

    task automatic t_erase_all();
        clear_logs();
        send(3'd5, 4'd0, 16'h0);
        idle(T_ERAL + 4);
        begin
            bit ok = (nlog == DEPTH);
            for (int i = 0; i < DEPTH; i++)
                if (log_a[i] != AW'(i) || log_d[i] != 16'hFFFF) ok = 0;
            check(ok, "R5 erase-all sweep", nlog, DEPTH);
        end
        check(busy_cnt == T_ERAL, "R7 erase-all length", busy_cnt, T_ERAL);
    endtask

    task automatic t_write_all();
        clear_logs();
        send(3'd6, 4'd0, 16'h1234);
        idle(T_WRAL + 4);
        begin
            bit ok = (nlog == 2 * DEPTH);
            for (int i = 0; i < DEPTH; i++) begin
                if (log_a[i] != AW'(i) || log_d[i] != 16'hFFFF) ok = 0;
                if (log_a[DEPTH + i] != AW'(i) || log_d[DEPTH + i] != 16'h1234) ok = 0;
            end
            check(ok, "R6 erase sweep then data sweep", nlog, 2 * DEPTH);
        end
        check(busy_cnt == T_WRAL, "R7 write-all length", busy_cnt, T_WRAL);
    endtask

    task automatic t_busy_ignores();
        clear_logs();
        send(3'd5, 4'd0, 16'h0);
        idle(3);
        cs = 1'b1;
        idle(1);
        cmd_valid = 1'b1; cmd_op = 3'd2;
        idle(1);
        cmd_valid = 1'b0;
        cs = 1'b0;
        idle(T_ERAL);
        check(busy_cnt == T_ERAL, "R9 cycle survives cs toggling", busy_cnt, T_ERAL);
        send(3'd4, 4'd5, 16'h0F0F);
        idle(T_WORD + 4);
        check(mem[5] == 16'h0F0F, "R10 disable during busy ignored", mem[5], 16'h0F0F);
    endtask

    task automatic t_cs_only();
        clear_logs();
        @(negedge clk) cs = 1'b1;
        idle(2);
        cs = 1'b0;
        idle(6);
        check(busy_cnt == 0, "R7 cs fall without command", busy_cnt, 0);
    endtask

    task automatic t_disable();
        send(3'd2, 4'd0, 16'h0);
        clear_logs();
        send(3'd3, 4'd5, 16'h0);
        idle(T_WORD + 4);
        check(nlog == 0 && mem[5] == 16'h0F0F, "R1 disable locks erase", mem[5], 16'h0F0F);
    endtask

    task automatic t_power();
        send(3'd1, 4'd0, 16'h0);
        clear_logs();
        send(3'd4, 4'd9, 16'hBEEF);
        idle(5);
        pwr_good = 1'b0;
        idle(3);
        check(busy == 0, "R11 cycle aborted on supply loss", busy, 0);
        pwr_good = 1'b1;
        idle(T_WORD);
        check(mem[9] == 16'hFFFF && nlog == 1, "R11 data phase suppressed", mem[9], 16'hFFFF);
        clear_logs();
        send(3'd4, 4'd9, 16'h1357);
        idle(T_WORD + 4);
        check(nlog == 0, "R1 supply loss cleared latch", nlog, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_locked();
        t_write_word();
        t_status_polled();
        t_status_silent();
        t_erase_all();
        t_write_all();
        t_busy_ignores();
        t_cs_only();
        t_disable();
        t_power();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule